// File: doc/BRIEF.md
# Direct-Mapped Cache with Timed Block Refill

This block is a direct-mapped cache that sits between a 32-bit processor port and a slower main-memory port. The memory port carries one or more 32-bit words per transfer. A processor request is split into three address fields. The two lowest address bits are ignored. The bits above them pick a word within a block, then an entry, and the remaining upper bits form the tag. When the entry is valid and its stored tag matches the address tag, the access completes at once. A read returns its word on the following cycle.

On a miss the cache stalls the processor and runs a fixed-timing sequence on the memory port. The sequence is one address cycle, then, for every memory-width chunk of the block, an access wait of `ACCESS_CYCLES` cycles followed by a one-cycle transfer. The whole block is loaded before the pending access is retried, and the retry then hits.

The parameter `WRITE_BACK` selects the write policy. With it clear, every store also posts a single-word write to memory. With it set, stores mark the entry dirty and stay in the cache. A miss on a dirty entry first writes the old block out, with the same timing, and only then fetches the new block. Store misses allocate: the block is fetched first and the store then lands on it.

Top module: `dmcache`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` and `mem_strobe` are low, and the first access to any address misses (`cpu_ready` low).
- R2: The entry index is (byte address / (BLOCK_WORDS*4)) mod ENTRIES. Address bits [1:0] are ignored. With 16-byte blocks and 64 entries, byte addresses 1200 and 2224 both use entry 11, and address 1216 uses entry 12.
- R3: A hit is accepted in the cycle it is presented (`cpu_ready` high). For a read, `rsp_valid` is high one cycle later, with the stored word on `rsp_rdata`.
- R4: A miss on a clean entry holds `cpu_ready` low for exactly 1+P cycles, where P = 1 + (BLOCK_WORDS/MEM_WORDS)*(ACCESS_CYCLES+1). For a 4-word block, P is 65, 33 or 17 for memory widths of 1, 2 or 4 words.
- R5: A refill makes exactly BLOCK_WORDS/MEM_WORDS read transfers (`mem_strobe` high, `mem_write` low). Their `mem_addr` values rise from the block base in steps of MEM_WORDS*4 bytes, and `mem_rdata` word w belongs to address `mem_addr`+4w.
- R6: With WRITE_BACK=0, a store updates the cache and, in the cycle after acceptance, makes one write transfer. That transfer carries the chunk-aligned address, the store word in every lane, and a `mem_wmask` with only bit ((address/4) mod MEM_WORDS) set.
- R7: With WRITE_BACK=1, a store hit makes no memory transfer and leaves memory unchanged, while later reads of the word return the stored value.
- R8: With WRITE_BACK=1, a miss on a dirty entry first writes the old block, with all mask bits set and addresses rising from the old block base, and then fetches the new block. `cpu_ready` stays low for 1+2P cycles.
- R9: A miss on a clean entry makes no write transfer.
- R10: A store miss refills the block and then writes the word into it. The other words of the block come from memory.
- R11: After a refill, every word of the block hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present; held until accepted |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request accepted this cycle (hit while idle) |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data |
| mem_strobe | output | 1 | Memory transfer this cycle |
| mem_write | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Byte address of the chunk |
| mem_wdata | output | MEM_WORDS*32 | Write data, lane w at mem_addr+4w |
| mem_wmask | output | MEM_WORDS | Per-lane write enable |
| mem_rdata | input | MEM_WORDS*32 | Read data for the addressed chunk, sampled on read transfers |

## Verification
A hit is accepted at the first rising edge after it is presented, and its read data is due one cycle later. The bench holds each request from a falling edge and counts the falling edges on which `cpu_ready` is low. That count must be 1+P for a clean miss, 1+2P for a dirty miss and 0 for a hit. The load word is pushed onto a queue before acceptance and popped by a monitor that samples `rsp_valid` on the next falling edge. Memory transfers are logged at falling edges. A posted write-through store is due exactly one cycle after acceptance, so the log is read only after one idle cycle following each access.

// File: rtl/dmcache.sv
module dmcache #(
  parameter int ENTRIES       = 64,
  parameter int BLOCK_WORDS   = 4,
  parameter int MEM_WORDS     = 1,
  parameter int ACCESS_CYCLES = 15,
  parameter bit WRITE_BACK    = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_valid,
  input  logic                   cpu_write,
  input  logic [31:0]            cpu_addr,
  input  logic [31:0]            cpu_wdata,
  output logic                   cpu_ready,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  output logic                   mem_strobe,
  output logic                   mem_write,
  output logic [31:0]            mem_addr,
  output logic [MEM_WORDS*32-1:0] mem_wdata,
  output logic [MEM_WORDS-1:0]   mem_wmask,
  input  logic [MEM_WORDS*32-1:0] mem_rdata
);
  localparam int WSEL_W  = $clog2(BLOCK_WORDS);
  localparam int OFF_W   = WSEL_W + 2;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int TAG_W   = 32 - IDX_W - OFF_W;
  localparam int CHUNKS  = BLOCK_WORDS / MEM_WORDS;
  localparam int CHK_W   = CHUNKS > 1 ? $clog2(CHUNKS) : 1;
  localparam int CNT_W   = $clog2(ACCESS_CYCLES + 1);
  localparam int BLK_W   = BLOCK_WORDS * 32;
  localparam int CHUNK_W = MEM_WORDS * 32;
  localparam int PENALTY = 1 + CHUNKS * (ACCESS_CYCLES + 1);

  typedef enum logic [1:0] {IDLE, ADDR, ACC, XFER} phase_t;
  phase_t state;

  logic [BLK_W-1:0] data_q [ENTRIES];
  logic [TAG_W-1:0] tag_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q, dirty_q;
  logic [IDX_W-1:0] m_idx;
  logic [TAG_W-1:0] m_tag;
  logic             evict;
  logic [CHK_W-1:0] chunk;
  logic [CNT_W-1:0] cnt;
  logic             wt_q;
  logic [31:0]      wt_addr, wt_data;

  wire [IDX_W-1:0]  idx  = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag  = cpu_addr[31 -: TAG_W];
  wire [WSEL_W-1:0] wsel = cpu_addr[2 +: WSEL_W];
  wire hit        = valid_q[idx] && (tag_q[idx] == tag);
  assign cpu_ready = (state == IDLE) && hit;
  wire accept     = cpu_valid && cpu_ready;
  wire last_chunk = chunk == CHK_W'(CHUNKS - 1);
  wire [TAG_W-1:0] seq_tag = evict ? tag_q[m_idx] : m_tag;
  wire [31:0] chunk_addr = {seq_tag, m_idx, OFF_W'(0)} + 32'(chunk) * 32'(MEM_WORDS * 4);

  logic unused_bits;
  assign unused_bits = &{1'b0, cpu_addr[1:0], wt_addr[1:0]};

  assign mem_strobe = wt_q || (state == XFER);
  assign mem_write  = wt_q || (state == XFER && evict);
  assign mem_addr   = wt_q ? (wt_addr & ~32'(MEM_WORDS * 4 - 1)) : chunk_addr;
  assign mem_wdata  = wt_q ? {MEM_WORDS{wt_data}} : data_q[m_idx][chunk*CHUNK_W +: CHUNK_W];
  assign mem_wmask  = wt_q ? (MEM_WORDS'(1) << (wt_addr[31:2] % MEM_WORDS))
                           : ((state == XFER && evict) ? '1 : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      valid_q   <= '0;
      dirty_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      wt_q      <= 1'b0;
      wt_addr   <= '0;
      wt_data   <= '0;
      evict     <= 1'b0;
      chunk     <= '0;
      cnt       <= '0;
      m_idx     <= '0;
      m_tag     <= '0;
    end else begin
      rsp_valid <= accept && !cpu_write;
      wt_q      <= accept && cpu_write && !WRITE_BACK;
      if (accept) begin
        rsp_rdata <= data_q[idx][wsel*32 +: 32];
        if (cpu_write) begin
          wt_addr <= cpu_addr;
          wt_data <= cpu_wdata;
          if (WRITE_BACK) dirty_q[idx] <= 1'b1;
        end
      end
      case (state)
        IDLE: if (cpu_valid && !hit) begin
          m_idx <= idx;
          m_tag <= tag;
          evict <= WRITE_BACK && valid_q[idx] && dirty_q[idx];
          chunk <= '0;
          state <= ADDR;
        end
        ADDR: begin
          cnt   <= '0;
          state <= ACC;
        end
        ACC: if (cnt == CNT_W'(ACCESS_CYCLES - 1)) state <= XFER;
             else cnt <= cnt + 1'b1;
        XFER: if (!last_chunk) begin
          chunk <= chunk + 1'b1;
          cnt   <= '0;
          state <= ACC;
        end else if (evict) begin
          evict          <= 1'b0;
          dirty_q[m_idx] <= 1'b0;
          chunk          <= '0;
          state          <= ADDR;
        end else begin
          valid_q[m_idx] <= 1'b1;
          dirty_q[m_idx] <= 1'b0;
          state          <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept && cpu_write) data_q[idx][wsel*32 +: 32] <= cpu_wdata;
    if (state == XFER && !evict) begin
      data_q[m_idx][chunk*CHUNK_W +: CHUNK_W] <= mem_rdata;
      if (last_chunk) tag_q[m_idx] <= m_tag;
    end
  end

  logic [15:0] busy_cyc, strb_cyc;
  logic        ev_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cyc <= '0;
      strb_cyc <= '0;
      ev_seen  <= 1'b0;
    end else if (state == IDLE) begin
      busy_cyc <= '0;
      strb_cyc <= '0;
      ev_seen  <= 1'b0;
    end else begin
      busy_cyc <= busy_cyc + 1'b1;
      strb_cyc <= strb_cyc + 16'(mem_strobe);
      if (mem_strobe && mem_write) ev_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && state == XFER && last_chunk && !evict) begin
      // R4 R8
      penalty_chk: assert (int'(busy_cyc) + 1 == (ev_seen ? 2 : 1) * PENALTY)
        else $error("refill length %0d", int'(busy_cyc) + 1);
      // R5
      strobe_count_chk: assert (int'(strb_cyc) + 1 == (ev_seen ? 2 : 1) * CHUNKS)
        else $error("transfer count %0d", int'(strb_cyc) + 1);
    end
  end

  // R3
  rsp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cpu_valid && cpu_ready && !cpu_write));

  // R6 R7
  store_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_write) |=> (mem_write == !WRITE_BACK));
endmodule

// File: tb/dmcache_bench.sv
module dmcache_env #(
  parameter bit WRITE_BACK = 1'b1,
  parameter int MEM_WORDS  = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CH = 4 / MEM_WORDS;
  localparam int P  = 1 + CH * 16;

  int checks = 0;
  int fails  = 0;

  logic cpu_valid = 0, cpu_write = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_ready, rsp_valid, mem_strobe, mem_write;
  logic [31:0] rsp_rdata, mem_addr;
  logic [MEM_WORDS*32-1:0] mem_wdata, mem_rdata;
  logic [MEM_WORDS-1:0] mem_wmask;

  dmcache #(.ENTRIES(64), .BLOCK_WORDS(4), .MEM_WORDS(MEM_WORDS),
            .ACCESS_CYCLES(15), .WRITE_BACK(WRITE_BACK)) u_dmcache (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_strobe(mem_strobe),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wmask(mem_wmask), .mem_rdata(mem_rdata));

  function automatic logic [31:0] initv(int i);
    return 32'hD000_0000 | 32'(i);
  endfunction

  logic [31:0] mem [1024];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= initv(i);
    end else if (mem_strobe && mem_write) begin
      for (int w = 0; w < MEM_WORDS; w++)
        if (mem_wmask[w]) mem[10'(mem_addr[11:2] + 10'(w))] <= mem_wdata[w*32 +: 32];
    end
  end
  always_comb
    for (int w = 0; w < MEM_WORDS; w++)
      mem_rdata[w*32 +: 32] = mem[10'(mem_addr[11:2] + 10'(w))];

  logic [31:0] lg_addr [$];
  bit          lg_wr   [$];
  logic [MEM_WORDS-1:0] lg_mask [$];
  always @(negedge clk)
    if (rst_n && mem_strobe) begin
      lg_addr.push_back(mem_addr);
      lg_wr.push_back(mem_write);
      lg_mask.push_back(mem_wmask);
    end

  task automatic clear_log();
    lg_addr.delete(); lg_wr.delete(); lg_mask.delete();
  endtask

  task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%m): got %0h expected %0h", req, got, exp);
    end
  endtask

  logic [31:0] expq [$];
  string       reqq [$];
  always @(negedge clk)
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) check(0, "R3", rsp_rdata, 32'hx);
      else begin
        automatic logic [31:0] e = expq.pop_front();
        automatic string r = reqq.pop_front();
        check(rsp_rdata == e, r, rsp_rdata, e);
      end
    end

  task automatic access(bit wr, logic [31:0] a, logic [31:0] d,
                        logic [31:0] expd, int exp_stall, string req);
    int stall = 0;
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ready) begin
      stall++;
      @(negedge clk);
      #1;
    end
    if (!wr) begin expq.push_back(expd); reqq.push_back(req); end
    @(negedge clk);
    cpu_valid = 0;
    @(negedge clk);
    check(stall == exp_stall, req, 32'(stall), 32'(exp_stall));
  endtask

  task automatic check_fetch(int first, logic [31:0] base, string req);
    for (int k = 0; k < CH; k++) begin
      check(lg_wr[first+k] == 0, req, 32'(lg_wr[first+k]), 0);
      check(lg_addr[first+k] == base + 32'(k*MEM_WORDS*4), req,
            lg_addr[first+k], base + 32'(k*MEM_WORDS*4));
    end
  endtask

  initial begin
    done = 0;
    @(posedge rst_n);
    @(negedge clk);
    cpu_addr = 1200;
    #1;
    // R1 reset state
    check(rsp_valid == 0, "R1", 32'(rsp_valid), 0);
    check(mem_strobe == 0, "R1", 32'(mem_strobe), 0);
    check(cpu_ready == 0, "R1", 32'(cpu_ready), 0);

    clear_log();
    access(0, 1200, 0, initv(300), 1 + P, "R4");
    check(lg_addr.size() == CH, "R5", 32'(lg_addr.size()), 32'(CH));
    if (lg_addr.size() == CH) check_fetch(0, 1200, "R5");
    access(0, 1212, 0, initv(303), 0, "R11");
    access(0, 1202, 0, initv(300), 0, "R2");
    access(0, 1204, 0, initv(301), 0, "R3");

    if (WRITE_BACK) begin
      access(0, 1216, 0, initv(304), 1 + P, "R2");
      clear_log();
      access(1, 1204, 32'hCAFE_0001, 0, 0, "R7");
      check(lg_addr.size() == 0, "R7", 32'(lg_addr.size()), 0);
      check(mem[301] == initv(301), "R7", mem[301], initv(301));
      access(0, 1204, 0, 32'hCAFE_0001, 0, "R7");
      clear_log();
      access(0, 2224, 0, initv(556), 1 + 2*P, "R8");
      check(lg_addr.size() == 2*CH, "R8", 32'(lg_addr.size()), 32'(2*CH));
      if (lg_addr.size() == 2*CH) begin
        for (int k = 0; k < CH; k++) begin
          check(lg_wr[k] == 1 && lg_mask[k] == '1, "R8", 32'(lg_wr[k]), 1);
          check(lg_addr[k] == 32'(1200 + k*MEM_WORDS*4), "R8", lg_addr[k], 32'(1200 + k*MEM_WORDS*4));
        end
        check_fetch(CH, 2224, "R8");
      end
      check(mem[301] == 32'hCAFE_0001, "R8", mem[301], 32'hCAFE_0001);
      clear_log();
      access(0, 1200, 0, initv(300), 1 + P, "R9");
      check(lg_addr.size() == CH, "R9", 32'(lg_addr.size()), 32'(CH));
      foreach (lg_wr[k]) check(lg_wr[k] == 0, "R9", 32'(lg_wr[k]), 0);
      access(1, 3248, 32'hBEEF_0002, 0, 1 + P, "R10");
      access(0, 3248, 0, 32'hBEEF_0002, 0, "R10");
      access(0, 3252, 0, initv(813), 0, "R10");
      check(mem[812] == initv(812), "R10", mem[812], initv(812));
    end else begin
      clear_log();
      access(1, 1208, 32'hFACE_0003, 0, 0, "R6");
      check(lg_addr.size() == 1, "R6", 32'(lg_addr.size()), 1);
      if (lg_addr.size() == 1) begin
        check(lg_wr[0] == 1, "R6", 32'(lg_wr[0]), 1);
        check(lg_addr[0] == 1208, "R6", lg_addr[0], 1208);
        check(lg_mask[0] == MEM_WORDS'(1), "R6", 32'(lg_mask[0]), 1);
      end
      check(mem[302] == 32'hFACE_0003, "R6", mem[302], 32'hFACE_0003);
      clear_log();
      access(1, 1212, 32'hFACE_0004, 0, 0, "R6");
      if (lg_addr.size() == 1) begin
        check(lg_addr[0] == 1208, "R6", lg_addr[0], 1208);
        check(lg_mask[0] == (MEM_WORDS'(1) << (1 % MEM_WORDS)), "R6", 32'(lg_mask[0]),
              32'(MEM_WORDS'(1) << (1 % MEM_WORDS)));
      end else check(0, "R6", 32'(lg_addr.size()), 1);
      check(mem[303] == 32'hFACE_0004, "R6", mem[303], 32'hFACE_0004);
      access(0, 1212, 0, 32'hFACE_0004, 0, "R6");
      clear_log();
      access(0, 2224, 0, initv(556), 1 + P, "R9");
      check(lg_addr.size() == CH, "R9", 32'(lg_addr.size()), 32'(CH));
      foreach (lg_wr[k]) check(lg_wr[k] == 0, "R9", 32'(lg_wr[k]), 0);
      access(0, 1208, 0, 32'hFACE_0003, 1 + P, "R4");
    end
    check(expq.size() == 0, "R3", 32'(expq.size()), 0);
    done = 1;
  end
endmodule

module dmcache_bench;
  localparam time CLK_PERIOD = 10ns;
  logic clk = 0;
  logic rst_n = 0;
  logic done_wb, done_wt;
  int   cycles = 0;
  int   wd_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmcache_env #(.WRITE_BACK(1'b1), .MEM_WORDS(1)) u_env_wb (.clk(clk), .rst_n(rst_n), .done(done_wb));
  dmcache_env #(.WRITE_BACK(1'b0), .MEM_WORDS(2)) u_env_wt (.clk(clk), .rst_n(rst_n), .done(done_wt));

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    while (!(done_wb && done_wt) && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(done_wb && done_wt)) begin
      wd_fail = 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    end
    $display("TB_RESULT checks=%0d failures=%0d",
             u_env_wb.checks + u_env_wt.checks + wd_fail,
             u_env_wb.fails + u_env_wt.fails + wd_fail);
    $finish;
  end
endmodule